// File: doc/BRIEF.md
# I2C Slave with Host-Selected Transfer Direction

This block is an I2C target peripheral. It sits behind a small register port that a host processor drives. SCL and SDA are first brought into the system clock domain. The block then finds START and STOP conditions and shifts in the 7-bit calling address. It compares that address with an own-address register. On a match it acknowledges the address, raises an address-hit flag and records the R/W bit.

The block does not turn the line around by itself. After every event (address acknowledged, data byte finished) it holds SCL low and raises a pending flag on `irq`. Firmware then writes a control bit that picks transmit or receive. It loads or collects the shared data register and releases the clock. As a receiver, the acknowledge level it drives comes from a control bit. As a transmitter, it records the master's acknowledge. On a NACK it lets go of SDA and stays silent until STOP.

The register port has four slots: control at 0, status at 1, data at 2 and own address at 3. Outputs `scl_oe` and `sda_oe` pull the open-drain lines low when they are 1.

Top module: `i2c_steered_slave`

## Requirements
- R1: A START (SDA falling while SCL high) sets the busy flag, status bit 3, and restarts address reception, even in the middle of a byte. A STOP (SDA rising while SCL high) clears busy and the address-hit flag.
- R2: After 8 address clocks, the block pulls SDA low during the ninth clock only when the first 7 bits, taken MSB first, equal the own-address register (slot 3, reset value 0x42). On a match it sets the address-hit flag, status bit 0.
- R3: On a match, the eighth address bit (1 = master reads) is stored in status bit 1.
- R4: After a calling address that does not match, the block never drives SDA or SCL until the next START.
- R5: In receive mode (control bit 0 = 0), eight SCL rising edges shift a byte in MSB first. The byte then reads back from data slot 2.
- R6: In receive mode, the block drives the ninth-clock acknowledge from control bit 1. A value of 0 pulls SDA low (ACK); a value of 1 leaves it released (NACK).
- R7: In transmit mode (control bit 0 = 1), the byte in data slot 2 appears on SDA MSB first, one bit per SCL clock.
- R8: In transmit mode, the master's ninth-clock SDA level is stored in status bit 2. If that level is 1, the block releases SDA, does not stretch, and stays off the bus until STOP.
- R9: After an address acknowledge and after each acknowledged byte, the block holds SCL low and sets the pending flag (status bit 4, also `irq`). It releases SCL after the host writes slot 2, reads slot 2, or writes status with bit 4 set. A NACKed transmit byte sets the pending flag but does not stretch SCL.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| reg_sel | input | 2 | Register slot: 0 control, 1 status, 2 data, 3 own address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected slot |
| irq | output | 1 | Pending event flag |

## Verification
The address compare is exercised with all 128 calling addresses against a fixed own address. A second pass re-runs the compare after the own address is reprogrammed, which shows whether the compare follows the register or a constant. Receive and transmit run the bit-distinct bytes 0x00, 0xFF, 0xA5, 0x5A, 0x01 and 0x80, which expose bit-order and inversion faults in the shifters. The acknowledge paths are checked with both ACK and NACK in each direction. A START issued mid-address shows whether the bit counter restarts. Line monitors catch SDA driven while ignored, SDA changing under a high SCL, and stretches that do not end when the host services the event.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W - 1;

  localparam logic [1:0] SLOT_CTRL = 2'd0;
  localparam logic [1:0] SLOT_STAT = 2'd1;
  localparam logic [1:0] SLOT_DATA = 2'd2;
  localparam logic [1:0] SLOT_ADDR = 2'd3;

  localparam int STAT_PEND_BIT = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_HOLD, S_LOAD,
    S_RX, S_RACK, S_TX, S_TACK, S_WSTOP
  } eng_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-2:0] own_addr,
  input  logic          tx_dir,
  input  logic          txak_lvl,
  input  logic [DW-1:0] tx_byte,
  input  logic          pend,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          ev_set,
  output logic          rx_load,
  output logic [DW-1:0] rx_byte,
  output logic          addr_hit,
  output logic          rw_flag,
  output logic          rxak,
  output logic          busy
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  eng_state_t       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DW-1:0]    sr_q, sr_n;
  logic             sda_q, sda_n, scl_q, scl_n;
  logic             tx_q, tx_n, hit_q, hit_n, rw_q, rw_n;
  logic             rxak_q, rxak_n, busy_q, busy_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sr_n    = sr_q;
    sda_n   = sda_q;
    tx_n    = tx_q;
    hit_n   = hit_q;
    rw_n    = rw_q;
    rxak_n  = rxak_q;
    busy_n  = busy_q;
    ev_set  = 1'b0;
    rx_load = 1'b0;
    if (start_det) begin
      st_n   = S_ADDR;
      cnt_n  = '0;
      sda_n  = 1'b0;
      busy_n = 1'b1;
      hit_n  = 1'b0;
    end else if (stop_det) begin
      st_n   = S_IDLE;
      cnt_n  = '0;
      sda_n  = 1'b0;
      busy_n = 1'b0;
      hit_n  = 1'b0;
    end else begin
      case (st_q)
        S_ADDR: begin
          if (scl_rise) begin
            sr_n  = {sr_q[DW-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (sr_q[DW-1:1] == own_addr) begin
              st_n  = S_AACK;
              sda_n = 1'b1;
              hit_n = 1'b1;
              rw_n  = sr_q[0];
            end else begin
              st_n = S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            st_n   = S_HOLD;
            sda_n  = 1'b0;
            ev_set = 1'b1;
          end
        end
        S_HOLD: begin
          if (!pend) begin
            st_n  = S_LOAD;
            cnt_n = '0;
            tx_n  = tx_dir;
            if (tx_dir) begin
              sr_n  = tx_byte;
              sda_n = ~tx_byte[DW-1];
            end else begin
              sda_n = 1'b0;
            end
          end
        end
        S_LOAD: st_n = tx_q ? S_TX : S_RX;
        S_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == FULL) begin
              st_n  = S_TACK;
              sda_n = 1'b0;
            end else begin
              sr_n  = {sr_q[DW-2:0], 1'b0};
              sda_n = ~sr_q[DW-2];
            end
          end
        end
        S_TACK: begin
          if (scl_rise) begin
            rxak_n = sda_s;
          end else if (scl_fall) begin
            ev_set = 1'b1;
            st_n   = rxak_q ? S_WSTOP : S_HOLD;
          end
        end
        S_RX: begin
          if (scl_rise) begin
            sr_n  = {sr_q[DW-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            rx_load = 1'b1;
            st_n    = S_RACK;
            sda_n   = ~txak_lvl;
          end
        end
        S_RACK: begin
          if (scl_fall) begin
            st_n   = S_HOLD;
            sda_n  = 1'b0;
            ev_set = 1'b1;
          end
        end
        default: ;
      endcase
    end
    scl_n = (st_n == S_HOLD) || (st_n == S_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sr_q   <= '0;
      sda_q  <= 1'b0;
      scl_q  <= 1'b0;
      tx_q   <= 1'b0;
      hit_q  <= 1'b0;
      rw_q   <= 1'b0;
      rxak_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sr_q   <= sr_n;
      sda_q  <= sda_n;
      scl_q  <= scl_n;
      tx_q   <= tx_n;
      hit_q  <= hit_n;
      rw_q   <= rw_n;
      rxak_q <= rxak_n;
      busy_q <= busy_n;
    end
  end

  assign sda_oe   = sda_q;
  assign scl_oe   = scl_q;
  assign rx_byte  = sr_q;
  assign addr_hit = hit_q;
  assign rw_flag  = rw_q;
  assign rxak     = rxak_q;
  assign busy     = busy_q;

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_q) || $fell(sda_q)) |-> !scl_s);
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> (!sda_q && !scl_q));
  a_r8_nack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WSTOP) |-> (!sda_q && !scl_q));
  a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy_q);
  a_r9_stretch_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOLD && pend) |-> scl_q);
endmodule

// File: rtl/i2cs_host_regs.sv
module i2cs_host_regs
  import i2cs_pkg::*;
#(
  parameter int             DW         = DATA_W,
  parameter int             AW         = ADDR_W,
  parameter logic [AW-1:0]  RESET_ADDR = 7'h42
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic          ev_set,
  input  logic          bus_cond,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_byte,
  input  logic          addr_hit,
  input  logic          rw_flag,
  input  logic          rxak,
  input  logic          busy,
  output logic [DW-1:0] rdata,
  output logic          tx_dir,
  output logic          txak_lvl,
  output logic [AW-1:0] own_addr,
  output logic [DW-1:0] tx_byte,
  output logic          pend
);
  logic [1:0]    ctrl_q, ctrl_n;
  logic [DW-1:0] data_q, data_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          pend_q, pend_n;
  logic          host_clr;

  assign host_clr = (sel == SLOT_DATA && (wr || rd)) ||
                    (sel == SLOT_STAT && wr && wdata[STAT_PEND_BIT]);

  always_comb begin
    ctrl_n = ctrl_q;
    data_n = data_q;
    addr_n = addr_q;
    if (wr && sel == SLOT_CTRL) ctrl_n = wdata[1:0];
    if (wr && sel == SLOT_ADDR) addr_n = wdata[AW-1:0];
    if (rx_load)                      data_n = rx_byte;
    else if (wr && sel == SLOT_DATA)  data_n = wdata;
    if (ev_set)        pend_n = 1'b1;
    else if (bus_cond) pend_n = 1'b0;
    else if (host_clr) pend_n = 1'b0;
    else               pend_n = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      addr_q <= RESET_ADDR;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      data_q <= data_n;
      addr_q <= addr_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    case (sel)
      SLOT_CTRL: rdata = {{(DW-2){1'b0}}, ctrl_q};
      SLOT_STAT: rdata = {{(DW-5){1'b0}}, pend_q, busy, rxak, rw_flag, addr_hit};
      SLOT_DATA: rdata = data_q;
      default:   rdata = {{(DW-AW){1'b0}}, addr_q};
    endcase
  end

  assign tx_dir   = ctrl_q[0];
  assign txak_lvl = ctrl_q[1];
  assign own_addr = addr_q;
  assign tx_byte  = data_q;
  assign pend     = pend_q;

  a_r9_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clr && !ev_set) |=> !pend_q);
  a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set |=> pend_q);
endmodule

// File: rtl/i2c_steered_slave.sv
module i2c_steered_slave
  import i2cs_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0]  RESET_ADDR  = 7'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [1:0] rst_ff;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s = rst_ff[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic tx_dir, txak_lvl, pend, ev_set, rx_load;
  logic addr_hit, rw_flag, rxak, busy;
  logic [ADDR_W-1:0] own_addr;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.DW(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_s), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .tx_dir(tx_dir), .txak_lvl(txak_lvl),
    .tx_byte(tx_byte), .pend(pend),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .ev_set(ev_set), .rx_load(rx_load),
    .rx_byte(rx_byte), .addr_hit(addr_hit), .rw_flag(rw_flag),
    .rxak(rxak), .busy(busy)
  );

  i2cs_host_regs #(.DW(DATA_W), .AW(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_s), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .ev_set(ev_set), .bus_cond(start_det | stop_det),
    .rx_load(rx_load), .rx_byte(rx_byte), .addr_hit(addr_hit),
    .rw_flag(rw_flag), .rxak(rxak), .busy(busy), .rdata(reg_rdata),
    .tx_dir(tx_dir), .txak_lvl(txak_lvl), .own_addr(own_addr),
    .tx_byte(tx_byte), .pend(pend)
  );

  assign irq = pend;
endmodule

// File: tb/test_i2c_steered_slave.sv
module test_i2c_steered_slave;
  localparam int Q = 8;
  localparam int WATCHDOG = 190000;

  logic clk, rst_n;
  logic scl_m, sda_m, scl_bus, sda_bus;
  logic scl_oe, sda_oe, irq;
  logic [1:0] reg_sel;
  logic reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;

  int tests, fails, cyc, drive_cnt, viol_cnt;
  logic watch, prev_sda_oe, finished;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_steered_slave i_i2c_steered_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_sda_oe <= sda_oe;
    if (watch && sda_oe) drive_cnt <= drive_cnt + 1;
    if (rst_n && (sda_oe != prev_sda_oe) && scl_bus) viol_cnt <= viol_cnt + 1;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_scl_high(); wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_scl_high(); wait_q(Q);
    sda_m = 1'b1; wait_q(2 * Q);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    sda_m = b; wait_q(Q);
    scl_m = 1'b1; wait_scl_high(); wait_q(Q);
    r = sda_bus; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic byte_out(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], r);
    bit_xfer(1'b1, ack);
  endtask

  task automatic byte_in(input logic ackbit, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      v[i] = r;
    end
    bit_xfer(ackbit, r);
  endtask

  logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

  initial begin
    logic ack, r;
    logic [7:0] d;
    tests = 0; fails = 0; cyc = 0; drive_cnt = 0; viol_cnt = 0;
    watch = 1'b0; finished = 1'b0; prev_sda_oe = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1;
    reg_sel = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    rst_n = 1'b0;
    wait_q(5);
    rst_n = 1'b1;
    wait_q(5);

    // reset state
    chk("R9 reset scl_oe", {31'd0, scl_oe}, 0);
    chk("R10 reset sda_oe", {31'd0, sda_oe}, 0);
    chk("R9 reset irq", {31'd0, irq}, 0);
    host_rd(2'd1, d); chk("R1 reset status", {24'd0, d}, 0);
    host_rd(2'd3, d); chk("R2 reset own address", {24'd0, d}, 32'h42);

    // R2/R4: full sweep of calling addresses against own address 0x42
    for (int a = 0; a < 128; a++) begin
      bus_start();
      byte_out({a[6:0], 1'b0}, ack);
      chk($sformatf("R2 ack for addr %0h", a), {31'd0, ack}, (a == 'h42) ? 0 : 1);
      if (a == 'h42) begin
        chk("R9 stretch after address", {31'd0, scl_oe}, 1);
        host_wr(2'd1, 8'h10);
      end else if (a % 32 == 5) begin
        drive_cnt = 0; watch = 1'b1;
        byte_out(8'h00, ack);
        watch = 1'b0;
        chk("R4 silent after mismatch", drive_cnt, 0);
        chk("R4 no ack after mismatch", {31'd0, ack}, 1);
      end
      bus_stop();
    end

    // write transaction: receive mode
    bus_start();
    host_rd(2'd1, d); chk("R1 busy after start", {31'd0, d[3]}, 1);
    byte_out({7'h42, 1'b0}, ack);
    chk("R2 match ack", {31'd0, ack}, 0);
    host_rd(2'd1, d);
    chk("R2 hit flag", {31'd0, d[0]}, 1);
    chk("R3 rw is write", {31'd0, d[1]}, 0);
    chk("R9 pending set", {31'd0, d[4]}, 1);
    host_wr(2'd0, 8'h00);
    host_wr(2'd1, 8'h10);
    wait_q(4);
    chk("R9 release on status clear", {31'd0, scl_oe}, 0);
    foreach (pats[k]) begin
      byte_out(pats[k], ack);
      chk("R6 receive ack", {31'd0, ack}, 0);
      chk("R9 stretch after byte", {31'd0, scl_oe}, 1);
      chk("R9 irq after byte", {31'd0, irq}, 1);
      host_rd(2'd2, d);
      chk($sformatf("R5 received byte %0h", pats[k]), {24'd0, d}, {24'd0, pats[k]});
      wait_q(4);
      chk("R9 release on data read", {31'd0, scl_oe}, 0);
    end
    host_wr(2'd0, 8'h02);
    byte_out(8'h3C, ack);
    chk("R6 nack from control", {31'd0, ack}, 1);
    host_rd(2'd2, d); chk("R5 byte under nack", {24'd0, d}, 32'h3C);
    host_wr(2'd0, 8'h00);
    bus_stop();
    host_rd(2'd1, d);
    chk("R1 busy cleared by stop", {31'd0, d[3]}, 0);
    chk("R1 hit cleared by stop", {31'd0, d[0]}, 0);

    // read transaction: transmit mode
    bus_start();
    byte_out({7'h42, 1'b1}, ack);
    chk("R2 match ack read", {31'd0, ack}, 0);
    host_rd(2'd1, d); chk("R3 rw is read", {31'd0, d[1]}, 1);
    host_wr(2'd0, 8'h01);
    host_wr(2'd2, pats[0]);
    for (int k = 0; k < 6; k++) begin
      byte_in((k == 5) ? 1'b1 : 1'b0, d);
      chk($sformatf("R7 sent byte %0h", pats[k]), {24'd0, d}, {24'd0, pats[k]});
      if (k < 5) begin
        host_rd(2'd1, d);
        chk("R8 rxak ack", {31'd0, d[2]}, 0);
        chk("R9 stretch in transmit", {31'd0, scl_oe}, 1);
        host_wr(2'd2, pats[k+1]);
      end
    end
    host_rd(2'd1, d);
    chk("R8 rxak nack", {31'd0, d[2]}, 1);
    chk("R8 no stretch after nack", {31'd0, scl_oe}, 0);
    drive_cnt = 0; watch = 1'b1;
    byte_in(1'b1, d);
    watch = 1'b0;
    chk("R8 released after nack", drive_cnt, 0);
    chk("R8 idle byte reads ones", {24'd0, d}, 32'hFF);
    bus_stop();
    host_wr(2'd0, 8'h00);
    host_wr(2'd1, 8'h10);

    // programmable own address
    host_wr(2'd3, 8'h17);
    bus_start();
    byte_out({7'h42, 1'b0}, ack);
    chk("R2 old address ignored", {31'd0, ack}, 1);
    bus_stop();
    bus_start();
    byte_out({7'h17, 1'b0}, ack);
    chk("R2 new address matched", {31'd0, ack}, 0);
    host_wr(2'd1, 8'h10);
    bus_stop();

    // START in the middle of an address restarts reception
    bus_start();
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, r);
    bus_start();
    byte_out({7'h17, 1'b0}, ack);
    chk("R1 restart mid byte", {31'd0, ack}, 0);
    host_wr(2'd1, 8'h10);
    bus_stop();

    chk("R10 sda moved only with scl low", viol_cnt, 0);
    finished = 1'b1;
    summary();
  end
endmodule